// File: doc/BRIEF.md
# Banked Mapper with Clock Snapshot Registers

This block sits between a CPU write path and a cartridge-style memory system. Writes into the lower half of the CPU address space do not store data. The top three address bits pick one of four control regions, and the written byte sets one of four things:

- the external RAM enable;
- a 7-bit ROM bank number;
- a selector that points the external window either at one of four RAM banks or at one of five clock registers;
- a latch handshake.

A seconds/minutes/hours/day counter runs from a one-cycle tick strobe. The latch handshake is a write of 0 followed by a write of 1. It copies the running time into five shadow bytes, which software can then read without the value changing between reads.

The read data for the external window comes from this block. It is the selected shadow byte when clock access is on. Otherwise it is the data from the external RAM when RAM is enabled, and 0xFF when it is not. The RAM array itself lives outside the block.

Two state machines hold the control state:

- **Selector machine.** It has states `SEL_RAM` and `SEL_CLOCK`.
  - Any state goes to `SEL_RAM` on a select write below 4.
  - Any state goes to `SEL_CLOCK` on a select write from 8 to 12.
  - Every other select value leaves the state where it is.
- **Latch machine.** It has states `LATCH_OPEN` and `LATCH_HELD`.
  - `LATCH_OPEN` goes to `LATCH_HELD` on a latch write of 1, and the snapshot is taken on that same edge.
  - `LATCH_HELD` goes back to `LATCH_OPEN` on a latch write of 0.
  - Every other write leaves the state unchanged.

Top module: `banked_clock_mapper`

## Requirements
- R1: The register region is `wr_region`, which is CPU address bits 15:13. Only regions 0 to 3 are control registers, and writes to regions 4 to 7 change nothing. A region-0 write of 0x0A sets `ram_en`, a region-0 write of 0x00 clears it, and any other region-0 value has no effect.
- R2: A region-1 write loads `rom_bank` with data bits 6:0, except that a value of zero in those bits loads 1. `rom_bank` is never zero.
- R3: A region-2 write of 0 to 3 loads `ram_bank` with that value and turns clock access off (`clk_access` = 0).
- R4: A region-2 write of 8 to 12 (0x08–0x0C) selects clock register index (value − 8) and turns clock access on. Region-2 values 4 to 7 and 13 to 255 change nothing.
- R5: A region-3 write of 1 while `snap_held` = 0 takes a snapshot and sets `snap_held`. A region-3 write of 0 while `snap_held` = 1 clears it. Every other region-3 write has no effect, and in particular a repeated 1 does not take a new snapshot.
- R6: The live counter advances once per cycle in which `sec_tick` is high. Seconds wrap at SEC_MOD into a minute step, minutes wrap at MIN_MOD into an hour step, and hours wrap at HR_MOD into a day step. The day count is 9 bits and wraps from 511 to 0. A snapshot captures the counter value held before the edge on which the snapshot is taken.
- R7: The clock register indices are 0 seconds, 1 minutes, 2 hours, 3 day bits 7:0, and 4 control. In the control byte:
  - bit 0 is day bit 8;
  - bits 3:1 read 0;
  - bits 7:4 hold CTRL_HI_INIT and are kept across every snapshot.
- R8: `ext_rdata` is the selected shadow byte when clock access is on. Otherwise it is `ram_rdata` when `ram_en` is 1, and 0xFF when `ram_en` is 0.
- R9: After reset:
  - `ram_en` = 0, `rom_bank` = 1, `ram_bank` = 0;
  - clock access is off, the clock register index is 0, and `snap_held` = 0;
  - the live counter and the shadow bytes are zero, except for the control byte's upper nibble, which holds CTRL_HI_INIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU control write strobe |
| wr_region | input | 3 | CPU write address bits 15:13 |
| wr_data | input | 8 | CPU write data |
| sec_tick | input | 1 | One-cycle pulse, one per elapsed second |
| ram_rdata | input | 8 | Read data from the external RAM array |
| ram_en | output | 1 | External RAM enabled |
| rom_bank | output | 7 | Switchable ROM bank number |
| ram_bank | output | 2 | Selected RAM bank |
| clk_access | output | 1 | Window points at the clock registers |
| snap_held | output | 1 | Snapshot latch flag |
| ext_rdata | output | 8 | Read data for the external window |

## Verification
The assertions check the following on every cycle:
- `rom_bank` is never zero;
- `ram_en` changes only after a region-0 write;
- clock access turns on only after a region-2 write in the 8–12 range;
- `snap_held` rises only after a region-3 write of 1 and falls only after a region-3 write of 0;
- the shadow bytes change only on the cycle that `snap_held` rises.

Several behaviours can only be shown by the bench's scenarios, which compare against a cycle model:
- the actual values captured, including the seconds/minutes/hours carries and the day bit 8 wrap;
- the preserved control nibble;
- the priority order of the read data selection;
- that ignored values leave every output unchanged.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam logic [2:0] REGION_ENABLE = 3'd0;
    localparam logic [2:0] REGION_ROM    = 3'd1;
    localparam logic [2:0] REGION_SEL    = 3'd2;
    localparam logic [2:0] REGION_LATCH  = 3'd3;

    localparam logic [7:0] KEY_ENABLE  = 8'h0A;
    localparam logic [7:0] KEY_DISABLE = 8'h00;

    localparam int CLK_REGS = 5;
    localparam int IDX_W    = $clog2(CLK_REGS);
    localparam int DAY_W    = 9;

    typedef enum logic {
        SEL_RAM   = 1'b0,
        SEL_CLOCK = 1'b1
    } sel_state_e;

    typedef enum logic {
        LATCH_OPEN = 1'b0,
        LATCH_HELD = 1'b1
    } latch_state_e;

    typedef struct packed {
        logic [7:0]       sec;
        logic [7:0]       min;
        logic [7:0]       hr;
        logic [DAY_W-1:0] day;
    } live_time_t;

endpackage

// File: rtl/mapper_rtc_counter.sv
module mapper_rtc_counter
    import mapper_pkg::*;
#(
    parameter int SEC_MOD = 60,
    parameter int MIN_MOD = 60,
    parameter int HR_MOD  = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    output live_time_t now
);

    localparam logic [7:0] SEC_LAST = 8'(SEC_MOD - 1);
    localparam logic [7:0] MIN_LAST = 8'(MIN_MOD - 1);
    localparam logic [7:0] HR_LAST  = 8'(HR_MOD - 1);

    live_time_t now_q;
    live_time_t now_d;

    always_comb begin
        now_d = now_q;
        if (tick) begin
            if (now_q.sec != SEC_LAST) begin
                now_d.sec = now_q.sec + 8'd1;
            end else begin
                now_d.sec = 8'd0;
                if (now_q.min != MIN_LAST) begin
                    now_d.min = now_q.min + 8'd1;
                end else begin
                    now_d.min = 8'd0;
                    if (now_q.hr != HR_LAST) begin
                        now_d.hr = now_q.hr + 8'd1;
                    end else begin
                        now_d.hr  = 8'd0;
                        now_d.day = now_q.day + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= '0;
        end else begin
            now_q <= now_d;
        end
    end

    assign now = now_q;

endmodule

// File: rtl/mapper_bank_regs.sv
module mapper_bank_regs
    import mapper_pkg::*;
#(
    parameter int ROM_W  = 7,
    parameter int RAMB_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_region,
    input  logic [7:0]        wr_data,
    output logic              ram_en,
    output logic [ROM_W-1:0]  rom_bank,
    output logic [RAMB_W-1:0] ram_bank,
    output logic              clk_access,
    output logic [IDX_W-1:0]  clk_idx
);

    localparam logic [7:0] RAM_LIMIT = 8'(1 << RAMB_W);
    localparam logic [7:0] CLK_FIRST = 8'h08;
    localparam logic [7:0] CLK_LAST  = 8'(8 + CLK_REGS - 1);

    sel_state_e        sel_q, sel_d;
    logic              en_q, en_d;
    logic [ROM_W-1:0]  rom_q, rom_d;
    logic [RAMB_W-1:0] bank_q, bank_d;
    logic [IDX_W-1:0]  idx_q, idx_d;

    logic hit_en, hit_rom, hit_sel;
    logic pick_ram, pick_clk;

    assign hit_en   = wr_en && (wr_region == REGION_ENABLE);
    assign hit_rom  = wr_en && (wr_region == REGION_ROM);
    assign hit_sel  = wr_en && (wr_region == REGION_SEL);
    assign pick_ram = hit_sel && (wr_data < RAM_LIMIT);
    assign pick_clk = hit_sel && (wr_data >= CLK_FIRST) && (wr_data <= CLK_LAST);

    // Selector state machine: next state
    always_comb begin
        sel_d = sel_q;
        unique case (sel_q)
            SEL_RAM: begin
                if (pick_clk) sel_d = SEL_CLOCK;
            end
            SEL_CLOCK: begin
                if (pick_ram) sel_d = SEL_RAM;
            end
            default: sel_d = SEL_RAM;
        endcase
    end

    // Data registers: next values
    always_comb begin
        en_d   = en_q;
        rom_d  = rom_q;
        bank_d = bank_q;
        idx_d  = idx_q;
        if (hit_en) begin
            if (wr_data == KEY_ENABLE)  en_d = 1'b1;
            if (wr_data == KEY_DISABLE) en_d = 1'b0;
        end
        if (hit_rom) begin
            rom_d = (wr_data[ROM_W-1:0] == '0) ? ROM_W'(1) : wr_data[ROM_W-1:0];
        end
        if (pick_ram) bank_d = wr_data[RAMB_W-1:0];
        if (pick_clk) idx_d  = IDX_W'(wr_data - CLK_FIRST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= SEL_RAM;
            en_q   <= 1'b0;
            rom_q  <= ROM_W'(1);
            bank_q <= '0;
            idx_q  <= '0;
        end else begin
            sel_q  <= sel_d;
            en_q   <= en_d;
            rom_q  <= rom_d;
            bank_q <= bank_d;
            idx_q  <= idx_d;
        end
    end

    assign ram_en     = en_q;
    assign rom_bank   = rom_q;
    assign ram_bank   = bank_q;
    assign clk_access = (sel_q == SEL_CLOCK);
    assign clk_idx    = idx_q;

endmodule

// File: rtl/mapper_latch_ctrl.sv
module mapper_latch_ctrl
    import mapper_pkg::*;
#(
    parameter logic [3:0] CTRL_HI_INIT = 4'h0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [7:0]                cmd_data,
    input  live_time_t                now,
    output logic                      held,
    output logic [CLK_REGS-1:0][7:0]  snap
);

    latch_state_e state_q, state_d;
    logic         take;
    logic [CLK_REGS-1:0][7:0] snap_q;

    // Latch state machine: next state and snapshot strobe
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            LATCH_OPEN: begin
                if (cmd_valid && cmd_data == 8'd1) begin
                    state_d = LATCH_HELD;
                    take    = 1'b1;
                end
            end
            LATCH_HELD: begin
                if (cmd_valid && cmd_data == 8'd0) begin
                    state_d = LATCH_OPEN;
                end
            end
            default: state_d = LATCH_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LATCH_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Shadow bytes, loaded only on the snapshot strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q    <= '0;
            snap_q[4] <= {CTRL_HI_INIT, 4'h0};
        end else if (take) begin
            snap_q[0] <= now.sec;
            snap_q[1] <= now.min;
            snap_q[2] <= now.hr;
            snap_q[3] <= now.day[7:0];
            snap_q[4] <= {snap_q[4][7:4], 3'b000, now.day[8]};
        end
    end

    assign held = (state_q == LATCH_HELD);
    assign snap = snap_q;

endmodule

// File: rtl/banked_clock_mapper.sv
module banked_clock_mapper
    import mapper_pkg::*;
#(
    parameter int         SEC_MOD      = 60,
    parameter int         MIN_MOD      = 60,
    parameter int         HR_MOD       = 24,
    parameter logic [3:0] CTRL_HI_INIT = 4'h0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_region,
    input  logic [7:0] wr_data,
    input  logic       sec_tick,
    input  logic [7:0] ram_rdata,
    output logic       ram_en,
    output logic [6:0] rom_bank,
    output logic [1:0] ram_bank,
    output logic       clk_access,
    output logic       snap_held,
    output logic [7:0] ext_rdata
);

    live_time_t               live;
    logic [IDX_W-1:0]         clk_idx;
    logic [CLK_REGS-1:0][7:0] snap_q;
    logic                     latch_cmd;
    logic [7:0]               clk_byte;

    assign latch_cmd = wr_en && (wr_region == REGION_LATCH);

    mapper_rtc_counter #(
        .SEC_MOD (SEC_MOD),
        .MIN_MOD (MIN_MOD),
        .HR_MOD  (HR_MOD)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sec_tick),
        .now   (live)
    );

    mapper_bank_regs #(
        .ROM_W  (7),
        .RAMB_W (2)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_region  (wr_region),
        .wr_data    (wr_data),
        .ram_en     (ram_en),
        .rom_bank   (rom_bank),
        .ram_bank   (ram_bank),
        .clk_access (clk_access),
        .clk_idx    (clk_idx)
    );

    mapper_latch_ctrl #(
        .CTRL_HI_INIT (CTRL_HI_INIT)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (latch_cmd),
        .cmd_data  (wr_data),
        .now       (live),
        .held      (snap_held),
        .snap      (snap_q)
    );

    always_comb begin
        clk_byte = 8'hFF;
        for (int i = 0; i < CLK_REGS; i++) begin
            if (clk_idx == IDX_W'(i)) clk_byte = snap_q[i];
        end
    end

    always_comb begin
        if (clk_access)  ext_rdata = clk_byte;
        else if (ram_en) ext_rdata = ram_rdata;
        else             ext_rdata = 8'hFF;
    end

endmodule

// File: rtl/mapper_checker.sv
module mapper_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [2:0]  wr_region,
    input logic [7:0]  wr_data,
    input logic [6:0]  rom_bank,
    input logic        ram_en,
    input logic        clk_access,
    input logic        snap_held,
    input logic [39:0] snap_flat
);

    // R2
    rom_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_bank != 7'd0);

    // R1
    ram_en_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en != $past(ram_en)) |-> $past(wr_en && wr_region == 3'd0));

    // R4
    clk_on_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_access) |-> $past(wr_en && wr_region == 3'd2 && wr_data >= 8'h08 && wr_data <= 8'h0C));

    // R5
    held_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snap_held) |-> $past(wr_en && wr_region == 3'd3 && wr_data == 8'd1));

    // R5
    held_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(snap_held) |-> $past(wr_en && wr_region == 3'd3 && wr_data == 8'd0));

    // R7
    snap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_flat != $past(snap_flat)) |-> $rose(snap_held));

endmodule

bind banked_clock_mapper mapper_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_region  (wr_region),
    .wr_data    (wr_data),
    .rom_bank   (rom_bank),
    .ram_en     (ram_en),
    .clk_access (clk_access),
    .snap_held  (snap_held),
    .snap_flat  (snap_q)
);

// File: tb/sim_banked_clock_mapper.sv
`timescale 1ns/1ps
module sim_banked_clock_mapper;

    localparam int         SEC_M = 4;
    localparam int         MIN_M = 3;
    localparam int         HR_M  = 2;
    localparam logic [3:0] HI    = 4'hA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_region = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       sec_tick = 1'b0;
    logic [7:0] ram_rdata = 8'd0;
    logic       ram_en, clk_access, snap_held;
    logic [6:0] rom_bank;
    logic [1:0] ram_bank;
    logic [7:0] ext_rdata;

    always #2.5 clk = ~clk;

    banked_clock_mapper #(
        .SEC_MOD (SEC_M), .MIN_MOD (MIN_M), .HR_MOD (HR_M), .CTRL_HI_INIT (HI)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_region (wr_region),
        .wr_data (wr_data), .sec_tick (sec_tick), .ram_rdata (ram_rdata),
        .ram_en (ram_en), .rom_bank (rom_bank), .ram_bank (ram_bank),
        .clk_access (clk_access), .snap_held (snap_held), .ext_rdata (ext_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Cycle model of the requirements
    bit         m_en, m_clk, m_held;
    logic [6:0] m_rom;
    logic [1:0] m_bank;
    int         m_idx;
    logic [7:0] m_snap [5];
    int         l_sec, l_min, l_hr, l_day;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_ext();
        if (m_clk) return m_snap[m_idx];
        if (m_en) return ram_rdata;
        return 8'hFF;
    endfunction

    task automatic model_reset();
        m_en = 0; m_clk = 0; m_held = 0; m_rom = 7'd1; m_bank = 2'd0; m_idx = 0;
        for (int i = 0; i < 4; i++) m_snap[i] = 8'h00;
        m_snap[4] = {HI, 4'h0};
        l_sec = 0; l_min = 0; l_hr = 0; l_day = 0;
    endtask

    task automatic model_step(input bit we, input logic [2:0] rg, input logic [7:0] d, input bit tk);
        if (we) begin
            case (rg)
                3'd0: begin
                    if (d == 8'h0A) m_en = 1;
                    else if (d == 8'h00) m_en = 0;
                end
                3'd1: m_rom = (d[6:0] == 7'd0) ? 7'd1 : d[6:0];
                3'd2: begin
                    if (d < 8'd4) begin m_bank = d[1:0]; m_clk = 0; end
                    else if (d >= 8'h08 && d <= 8'h0C) begin m_idx = int'(d) - 8; m_clk = 1; end
                end
                3'd3: begin
                    if (!m_held && d == 8'd1) begin
                        m_snap[0] = 8'(l_sec); m_snap[1] = 8'(l_min); m_snap[2] = 8'(l_hr);
                        m_snap[3] = 8'(l_day); m_snap[4] = {m_snap[4][7:4], 3'b000, 1'((l_day >> 8) & 1)};
                        m_held = 1;
                    end else if (m_held && d == 8'd0) m_held = 0;
                end
                default: ;
            endcase
        end
        if (tk) begin
            l_sec++;
            if (l_sec == SEC_M) begin
                l_sec = 0; l_min++;
                if (l_min == MIN_M) begin
                    l_min = 0; l_hr++;
                    if (l_hr == HR_M) begin l_hr = 0; l_day = (l_day + 1) % 512; end
                end
            end
        end
    endtask

    task automatic compare_all();
        chk("R1 ram_en", {7'd0, ram_en}, {7'd0, m_en});
        chk("R2 rom_bank", {1'b0, rom_bank}, {1'b0, m_rom});
        chk("R3 ram_bank", {6'd0, ram_bank}, {6'd0, m_bank});
        chk("R4 clk_access", {7'd0, clk_access}, {7'd0, m_clk});
        chk("R5 snap_held", {7'd0, snap_held}, {7'd0, m_held});
        chk(m_clk ? "R6 R7 clock byte" : "R8 window data", ext_rdata, exp_ext());
    endtask

    task automatic step(input bit we, input logic [2:0] rg, input logic [7:0] d, input bit tk);
        @(negedge clk);
        wr_en = we; wr_region = rg; wr_data = d; sec_tick = tk;
        ram_rdata = 8'($urandom);
        #1;
        compare_all();
        @(posedge clk);
        model_step(we, rg, d, tk);
    endtask

    task automatic read_all_clock();
        for (int i = 0; i < 5; i++) step(1, 3'd2, 8'(8 + i), 0);
        step(0, 3'd0, 8'd0, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        chk("R9 ram_en", {7'd0, ram_en}, 8'd0);
        chk("R9 rom_bank", {1'b0, rom_bank}, 8'd1);
        chk("R9 ram_bank", {6'd0, ram_bank}, 8'd0);
        chk("R9 clk_access", {7'd0, clk_access}, 8'd0);
        chk("R9 snap_held", {7'd0, snap_held}, 8'd0);
        chk("R9 window off", ext_rdata, 8'hFF);

        // R1 enable keys, ignored values, high regions
        step(1, 3'd0, 8'h0A, 0);
        step(1, 3'd0, 8'h05, 0);
        step(1, 3'd0, 8'h00, 0);
        step(1, 3'd5, 8'h0A, 0);
        step(1, 3'd0, 8'h0A, 0);
        // R2 zero maps to 1, top bit dropped
        step(1, 3'd1, 8'h00, 0);
        step(1, 3'd1, 8'hFF, 0);
        step(1, 3'd1, 8'h80, 0);
        // R3 R4 selector, including ignored values
        step(1, 3'd2, 8'h03, 0);
        step(1, 3'd2, 8'h05, 0);
        step(1, 3'd2, 8'h0C, 0);
        step(1, 3'd2, 8'h0D, 0);
        step(1, 3'd2, 8'h07, 0);
        step(1, 3'd2, 8'h01, 0);
        // R6 count, R5 handshake with repeats
        for (int i = 0; i < 30; i++) step(0, 3'd0, 8'd0, 1);
        step(1, 3'd3, 8'd1, 1);
        read_all_clock();
        for (int i = 0; i < 7; i++) step(0, 3'd0, 8'd0, 1);
        step(1, 3'd3, 8'd1, 0);
        read_all_clock();
        step(1, 3'd3, 8'd0, 0);
        step(1, 3'd3, 8'd0, 0);
        step(1, 3'd3, 8'd2, 0);
        step(1, 3'd3, 8'd1, 0);
        read_all_clock();

        // Random phase; long enough for the day count to pass 256 and wrap
        for (int i = 0; i < 15000; i++) begin
            logic [7:0] d;
            int pick = $urandom_range(0, 5);
            case (pick)
                0: d = 8'h00;
                1: d = 8'h0A;
                2: d = 8'h01;
                3: d = 8'($urandom_range(0, 15));
                default: d = 8'($urandom);
            endcase
            step(($urandom_range(0, 1) == 1), 3'($urandom_range(0, 7)), d,
                 ($urandom_range(0, 15) != 0));
        end
        // Final snapshot and full read
        step(1, 3'd3, 8'd0, 0);
        step(1, 3'd3, 8'd1, 0);
        read_all_clock();
        step(1, 3'd2, 8'd2, 0);
        step(1, 3'd0, 8'h00, 0);
        step(0, 3'd0, 8'd0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule